// File: doc/BRIEF.md
# Oscillator Power-Down Wake Controller

This block holds an 8-bit auxiliary timing register. Its top bit is a software-set control that turns off the crystal oscillator to save power. The block drives that control out as the oscillator-off enable. Firmware sets the bit with an ordinary register write. The block clears it again by itself when the host interface shows activity that needs the clock running.

Four host events wake the oscillator. Some of them count only when this drive is the one addressed. A command written to this drive wakes it. A diagnostic command wakes it whichever drive is addressed. When shadow-drive emulation is on, a command aimed at the other (shadow) drive also wakes it. A host soft-reset request wakes it with no regard to drive selection. All event inputs arrive as single-cycle pulses that are already synchronous to the register clock.

Chip, host and firmware resets each clear the whole register. Bit 6 is reserved. Bits 5:0 are plain storage for other timing controls.

Top module: `osc_wake_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the register is loaded with 8'h00, so `reg_rdata` reads 8'h00 and `osc_off` is 0.
- R2: A host reset (`host_rst`) or a firmware reset (`fw_rst`) at a clock edge clears all 8 register bits. It also overrides a register write in the same cycle.
- R3: A write (`reg_wr`) with `reg_wdata[7]`=1 and no wake event sets bit 7, which is the oscillator-off bit. `osc_off` and `reg_rdata[7]` are then 1 from the cycle after that edge onward.
- R4: Bit 6 is reserved. It always reads 0, and writing 1 to it has no effect.
- R5: Bits 5:0 take the written value on a write. A wake event does not change them.
- R6: A pulse on `cmd_wr` while `drv_sel` is 1 (this drive addressed) clears bit 7 at that edge.
- R7: A pulse on `cmd_wr` with `drv_sel`=0, `cmd_diag`=0 and `shadow_en`=0 leaves the register unchanged.
- R8: A pulse on `cmd_wr` with `cmd_diag`=1 clears bit 7 whatever the value of `drv_sel`.
- R9: With `shadow_en`=1, a pulse on `cmd_wr` with `drv_sel`=0 (a command to the shadow drive) clears bit 7.
- R10: A pulse on `srst_set` clears bit 7 whatever the values of `drv_sel` and `cmd_wr`.
- R11: If a wake event and a write of 1 to bit 7 happen in the same cycle, bit 7 ends up 0. Bits 5:0 still take the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Chip reset, synchronous, active high |
| host_rst | input | 1 | Host reset pulse, clears the register |
| fw_rst | input | 1 | Firmware reset pulse, clears the register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents |
| cmd_wr | input | 1 | Host command-register write pulse |
| drv_sel | input | 1 | 1 when this drive is the one addressed |
| cmd_diag | input | 1 | Qualifies `cmd_wr` as a diagnostic command |
| shadow_en | input | 1 | Shadow-drive emulation enable |
| srst_set | input | 1 | Pulse when the host sets the soft-reset bit |
| osc_off | output | 1 | Oscillator-off enable |

## Verification
The bench covers each way a command can or cannot wake the oscillator:
- A command to the other drive with shadow emulation off must leave the bit set. A design that ignores drive selection would wrongly wake.
- A diagnostic command or a soft reset must wake even when this drive is not addressed. A design that gates every event on selection would stay asleep.

It also drives a wake event and a write of 1 in the same cycle. A design that gives the write priority would leave the oscillator off. A design that drops the whole write would lose bits 5:0.

Finally, it writes 1 to the reserved bit, and it applies resets together with writes. These catch storage that is too wide and resets that lose to writes.

// File: rtl/osc_wake_pkg.sv
package osc_wake_pkg;

    localparam int unsigned AUX_W       = 8;
    localparam int unsigned OFF_POS     = 7;
    localparam int unsigned RSVD_POS    = 6;
    localparam int unsigned N_CLR_SRC   = 2;

    // Qualified wake sources, one flag per host event class
    typedef struct packed {
        logic own_cmd;
        logic diag_cmd;
        logic shadow_cmd;
        logic soft_rst;
    } wake_src_t;

    // Per-cycle update request handed to the storage
    typedef struct packed {
        logic clr_all;
        logic wake;
        logic wr;
    } upd_req_t;

    // Mask of bits that software may write
    function automatic logic [AUX_W-1:0] wr_mask(input int unsigned rsvd);
        logic [AUX_W-1:0] m;
        m = '1;
        m[rsvd] = 1'b0;
        return m;
    endfunction

    function automatic logic any_wake(input wake_src_t s);
        return s.own_cmd | s.diag_cmd | s.shadow_cmd | s.soft_rst;
    endfunction

endpackage

// File: rtl/osc_wake_detect.sv
module osc_wake_detect
    import osc_wake_pkg::*;
(
    input  logic cmd_wr,
    input  logic drv_sel,
    input  logic cmd_diag,
    input  logic shadow_en,
    input  logic srst_set,
    output logic wake
);
    wake_src_t src;

    always_comb begin
        src.own_cmd    = cmd_wr & drv_sel;
        src.diag_cmd   = cmd_wr & cmd_diag;
        src.shadow_cmd = cmd_wr & shadow_en & ~drv_sel;
        src.soft_rst   = srst_set;
        wake           = any_wake(src);
    end
endmodule

// File: rtl/osc_clear_merge.sv
module osc_clear_merge #(
    parameter int unsigned N_SRC = 2
) (
    input  logic [N_SRC-1:0] clr_src,
    output logic             clr_all
);
    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N_SRC; i++) begin : g_or
        assign chain[i+1] = chain[i] | clr_src[i];
    end
    assign clr_all = chain[N_SRC];
endmodule

// File: rtl/osc_aux_reg.sv
module osc_aux_reg
    import osc_wake_pkg::*;
#(
    parameter int unsigned REG_W    = AUX_W,
    parameter int unsigned OFF_BIT  = OFF_POS,
    parameter int unsigned RSVD_BIT = RSVD_POS
) (
    input  logic             clk,
    input  logic             rst,
    input  upd_req_t         req,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    localparam logic [REG_W-1:0] WMASK = REG_W'(wr_mask(RSVD_BIT));

    logic [REG_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (req.wr)
            nxt = wdata & WMASK;
        if (req.wake)
            nxt[OFF_BIT] = 1'b0;
        if (req.clr_all)
            nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end
endmodule

// File: rtl/osc_wake_ctrl.sv
module osc_wake_ctrl
    import osc_wake_pkg::*;
#(
    parameter int unsigned REG_W    = AUX_W,
    parameter int unsigned OFF_BIT  = OFF_POS,
    parameter int unsigned RSVD_BIT = RSVD_POS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_rst,
    input  logic             fw_rst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cmd_wr,
    input  logic             drv_sel,
    input  logic             cmd_diag,
    input  logic             shadow_en,
    input  logic             srst_set,
    output logic             osc_off
);
    logic     wake;
    logic     clr_all;
    upd_req_t req;

    osc_wake_detect u_det (
        .cmd_wr    (cmd_wr),
        .drv_sel   (drv_sel),
        .cmd_diag  (cmd_diag),
        .shadow_en (shadow_en),
        .srst_set  (srst_set),
        .wake      (wake)
    );

    osc_clear_merge #(.N_SRC(N_CLR_SRC)) u_clr (
        .clr_src ({fw_rst, host_rst}),
        .clr_all (clr_all)
    );

    always_comb begin
        req.clr_all = clr_all;
        req.wake    = wake;
        req.wr      = reg_wr;
    end

    osc_aux_reg #(
        .REG_W    (REG_W),
        .OFF_BIT  (OFF_BIT),
        .RSVD_BIT (RSVD_BIT)
    ) u_reg (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .wdata (reg_wdata),
        .q     (reg_rdata)
    );

    assign osc_off = reg_rdata[OFF_BIT];
endmodule

// File: rtl/osc_wake_chk.sv
module osc_wake_chk #(
    parameter int unsigned REG_W    = 8,
    parameter int unsigned OFF_BIT  = 7,
    parameter int unsigned RSVD_BIT = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             host_rst,
    input logic             fw_rst,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             cmd_wr,
    input logic             drv_sel,
    input logic             cmd_diag,
    input logic             shadow_en,
    input logic             srst_set,
    input logic             osc_off
);
    logic clr;
    assign clr = host_rst | fw_rst;

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> reg_rdata == '0);

    assert_set_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_wdata[OFF_BIT] && !clr && !srst_set && !cmd_wr |=> osc_off);

    assert_rsvd_R4: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[RSVD_BIT] == 1'b0);

    assert_low_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (srst_set || cmd_wr) && !reg_wr && !clr |=> $stable(reg_rdata[OFF_BIT-1:0]));

    assert_own_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && drv_sel |=> !osc_off);

    assert_other_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !drv_sel && !cmd_diag && !shadow_en && !srst_set && !reg_wr && !clr
        |=> $stable(reg_rdata));

    assert_diag_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && cmd_diag |=> !osc_off);

    assert_shadow_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && shadow_en && !drv_sel |=> !osc_off);

    assert_srst_R10: assert property (@(posedge clk) disable iff (rst)
        srst_set |=> !osc_off);
endmodule

bind osc_wake_ctrl osc_wake_chk #(
    .REG_W    (REG_W),
    .OFF_BIT  (OFF_BIT),
    .RSVD_BIT (RSVD_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_rst  (host_rst),
    .fw_rst    (fw_rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cmd_wr    (cmd_wr),
    .drv_sel   (drv_sel),
    .cmd_diag  (cmd_diag),
    .shadow_en (shadow_en),
    .srst_set  (srst_set),
    .osc_off   (osc_off)
);

// File: tb/tb_osc_wake_ctrl.sv
module tb_osc_wake_ctrl;

    typedef struct packed {
        logic       hr;
        logic       fr;
        logic       wr;
        logic [7:0] wd;
        logic       cmd;
        logic       sel;
        logic       diag;
        logic       sh;
        logic       srst;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    // Expected register value after each vector, starting from 8'h00
    localparam vec_t VT [NV] = '{
        '{0,0,1,8'hFF,0,0,0,0,0,8'hBF,4'd4},  // R4 R3: bit 6 ignored
        '{0,0,0,8'h00,1,0,0,0,0,8'hBF,4'd7},  // R7 other drive, no shadow
        '{0,0,0,8'h00,1,1,0,0,0,8'h3F,4'd6},  // R6 own drive; R5 low bits kept
        '{0,0,1,8'h80,0,0,0,0,0,8'h80,4'd3},  // R3
        '{0,0,0,8'h00,1,0,1,0,0,8'h00,4'd8},  // R8 diag, other drive
        '{0,0,1,8'h95,0,0,0,0,0,8'h95,4'd5},  // R5 write low bits
        '{0,0,0,8'h00,1,0,0,1,0,8'h15,4'd9},  // R9 shadow command
        '{0,0,1,8'hAA,0,0,0,0,0,8'hAA,4'd3},  // R3
        '{0,0,0,8'h00,0,0,0,0,1,8'h2A,4'd10}, // R10 soft reset
        '{0,0,1,8'hC1,0,0,0,0,1,8'h01,4'd11}, // R11 wake beats write
        '{0,0,1,8'h81,0,0,0,0,0,8'h81,4'd3},  // R3
        '{0,0,0,8'h00,1,1,0,1,0,8'h01,4'd6},  // R6 own drive, shadow on
        '{0,0,1,8'hBF,0,0,0,0,0,8'hBF,4'd3},  // R3
        '{0,0,0,8'h00,0,0,0,0,0,8'hBF,4'd3},  // R3 hold while idle
        '{1,0,0,8'h00,0,0,0,0,0,8'h00,4'd2},  // R2 host reset
        '{0,0,1,8'h8C,0,0,0,0,0,8'h8C,4'd3},  // R3
        '{0,1,1,8'hFF,0,0,0,0,0,8'h00,4'd2},  // R2 fw reset beats write
        '{0,0,1,8'h80,1,1,0,0,0,8'h00,4'd11}, // R11 command with write
        '{0,0,1,8'h85,0,0,0,0,0,8'h85,4'd3},  // R3
        '{0,0,0,8'h00,1,0,0,0,0,8'h85,4'd7},  // R7
        '{0,0,0,8'h00,0,1,1,1,1,8'h05,4'd10}  // R10 with other qualifiers
    };

    logic       clk = 1'b0;
    logic       rst, host_rst, fw_rst, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       cmd_wr, drv_sel, cmd_diag, shadow_en, srst_set, osc_off;
    int         checks = 0;
    int         fails  = 0;

    always #4 clk = ~clk;

    osc_wake_ctrl dut (
        .clk(clk), .rst(rst), .host_rst(host_rst), .fw_rst(fw_rst),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_wr(cmd_wr), .drv_sel(drv_sel), .cmd_diag(cmd_diag),
        .shadow_en(shadow_en), .srst_set(srst_set), .osc_off(osc_off)
    );

    task automatic check(input int rq, input logic [7:0] exp);
        checks++;
        if (reg_rdata !== exp || osc_off !== exp[7]) begin
            fails++;
            $display("FAIL R%0d: rdata=%h osc_off=%b expected rdata=%h osc_off=%b",
                     rq, reg_rdata, osc_off, exp, exp[7]);
        end
    endtask

    task automatic idle();
        host_rst = 0; fw_rst = 0; reg_wr = 0; reg_wdata = '0;
        cmd_wr = 0; drv_sel = 0; cmd_diag = 0; shadow_en = 0; srst_set = 0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 8'h00);               // R1 reset state
        rst = 0;
        for (int i = 0; i < NV; i++) begin
            host_rst = VT[i].hr; fw_rst = VT[i].fr; reg_wr = VT[i].wr;
            reg_wdata = VT[i].wd; cmd_wr = VT[i].cmd; drv_sel = VT[i].sel;
            cmd_diag = VT[i].diag; shadow_en = VT[i].sh; srst_set = VT[i].srst;
            @(posedge clk);
            @(negedge clk);
            idle();
            check(int'(VT[i].req), VT[i].exp);
        end
        // R1: chip reset wins over a write in the same cycle
        reg_wr = 1; reg_wdata = 8'hBF;
        @(posedge clk); @(negedge clk);
        idle();
        check(3, 8'hBF);
        rst = 1; reg_wr = 1; reg_wdata = 8'hFF;
        @(posedge clk); @(negedge clk);
        rst = 0; idle();
        check(1, 8'h00);
        // R11: diag wake with write of 1 on other drive keeps low bits
        reg_wr = 1; reg_wdata = 8'hA3; cmd_wr = 1; cmd_diag = 1;
        @(posedge clk); @(negedge clk);
        idle();
        check(11, 8'h23);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule